// File: doc/BRIEF.md
# LIN Receive Checksum Compare Scheduler

This block sits next to a byte-oriented LIN receiver and decides which received byte of an extended frame is the checksum byte. It keeps an 8-bit running sum with end-around carry over the data bytes of the current frame. At frame start that sum may be seeded with the protected identifier. The selected checksum byte is compared against the running sum, and the block reports the outcome.

Software arms the compare with a request bit. The request is honoured only in LIN mode. In single-buffer mode the next accepted byte is the checksum byte. In multi-buffer mode the choice depends on when the request was armed. If it was armed while frame data was still arriving, the checksum is the byte that follows the programmed number of data bytes. If it was armed during the inter-frame idle period, the checksum is the very next byte. The request clears itself once its compare completes.

Received bytes enter through a valid/ready stream. A byte is taken on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low only during reset, so the block never applies back-pressure. The receiver must hold `rx_data` stable only on the cycle it asserts `rx_valid`.

Top module: `lin_cksum_sched`

## Requirements
- R1: While reset is asserted, `req_rb`, `ck_err` and `cmp_done` are 0 and `rx_ready` is 0. From the first clock after reset, `rx_ready` is 1 and stays 1.
- R2: A `req_set` pulse with `lin_mode`=1 makes `req_rb` read 1 on the next cycle. A `req_set` with `lin_mode`=0 is ignored and `req_rb` stays 0.
- R3: With `multi_buf`=0, the first byte accepted after the request is armed is the checksum byte. Every earlier byte is added to the sum as data.
- R4: With `multi_buf`=1 and the request armed while `frame_idle`=0, accepted bytes are data until `data_cnt`+1 of them have arrived in the frame. `data_cnt` is 3 bits, so a value of 0 means 1 byte and 7 means 8 bytes. The next byte is the checksum, and no compare result appears before it.
- R5: With `multi_buf`=1 and the request armed while `frame_idle`=1, the next accepted byte is the checksum byte, whatever the data count.
- R6: The running sum is formed by 8-bit addition with end-around carry over the data bytes. When `frm_start` is pulsed with `pid_incl`=1, the sum starts at `pid_data`; otherwise it starts at 0. The compare passes when the sum added to the checksum byte, with end-around carry, equals 0xFF.
- R7: `cmp_done` is high for exactly the one cycle after the checksum byte is accepted. On that same edge `req_rb` returns to 0, unless `req_set` is also pulsed.
- R8: A failing compare sets `ck_err`. The flag stays set, through later passing compares, until an `err_clr` pulse clears it. A new failure in the same cycle as `err_clr` wins.
- R9: `req_clr` clears the request. If it coincides with acceptance of the checksum byte, that byte is dropped, no `cmp_done` pulse occurs, `ck_err` is unchanged, and the sum is unchanged.
- R10: Both the running sum and the data count restart at `frm_start` and after every completed compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lin_mode | input | 1 | High when the block runs in LIN mode |
| multi_buf | input | 1 | Multi-buffer mode select |
| data_cnt | input | 3 | Programmed data byte count minus one |
| frame_idle | input | 1 | High during the inter-frame idle period |
| frm_start | input | 1 | Pulse marking the start of a frame |
| pid_incl | input | 1 | Seed the sum with `pid_data` at frame start |
| pid_data | input | 8 | Protected identifier |
| req_set | input | 1 | Software write of one to the request bit |
| req_clr | input | 1 | Software write of zero to the request bit |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Block accepts a byte |
| rx_data | input | 8 | Received byte |
| cmp_done | output | 1 | One-cycle pulse after a completed compare |
| ck_err | output | 1 | Sticky checksum mismatch flag |
| req_rb | output | 1 | Readback of the request bit |

## Verification
The assertions assume that `frm_start` never coincides with an accepted byte. They also assume that `req_set` and `req_clr` are never pulsed together, and that `lin_mode` changes only while no request is armed. The stimulus drives every pulse for a single cycle from tasks that advance one falling edge at a time. This keeps frame starts, request writes and byte transfers on separate cycles. `lin_mode` is lowered only in a directed step that runs with the request bit clear.

// File: rtl/lin_ck_pkg.sv
package lin_ck_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_FIELD_W = 3;
  localparam logic [BYTE_W-1:0] CK_PASS = {BYTE_W{1'b1}};

  // 8-bit addition with end-around carry
  function automatic logic [BYTE_W-1:0] ck_add(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
  endfunction
endpackage

// File: rtl/ck_req_ctrl.sv
module ck_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lin_mode,
  input  logic req_set,
  input  logic req_clr,
  input  logic frame_idle,
  input  logic ck_fire,
  output logic req,
  output logic idle_arm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= 1'b0;
      idle_arm <= 1'b0;
    end else if (req_clr) begin
      req <= 1'b0;
    end else if (req_set && lin_mode) begin
      req      <= 1'b1;
      idle_arm <= frame_idle;
    end else if (ck_fire) begin
      req <= 1'b0;
    end
  end

  // R2
  ignore_off_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set && !lin_mode && !req) |=> !req);
  // R9
  clr_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |=> !req);
endmodule

// File: rtl/ck_byte_sel.sv
module ck_byte_sel #(
  parameter int CNT_FIELD_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic                   frm_start,
  input  logic                   req,
  input  logic                   idle_arm,
  input  logic                   req_clr,
  input  logic                   multi_buf,
  input  logic [CNT_FIELD_W-1:0] data_cnt,
  output logic                   ck_fire,
  output logic                   data_fire
);
  localparam int CW = CNT_FIELD_W + 1;
  localparam logic [CW-1:0] CMAX = CW'(1 << CNT_FIELD_W);

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          cand;

  assign target    = {1'b0, data_cnt} + CW'(1);
  assign cand      = fire && req && (!multi_buf || idle_arm || (cnt >= target));
  assign ck_fire   = cand && !req_clr;
  assign data_fire = fire && !cand;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (frm_start || ck_fire)     cnt <= '0;
    else if (data_fire && cnt < CMAX)  cnt <= cnt + CW'(1);
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);
  // R10
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start || ck_fire) |=> cnt == '0);
endmodule

// File: rtl/ck_sum_acc.sv
module ck_sum_acc
  import lin_ck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              pid_incl,
  input  logic [BYTE_W-1:0] pid_data,
  input  logic              data_fire,
  input  logic              ck_fire,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              match
);
  logic [BYTE_W-1:0] sum;

  assign match = (ck_add(sum, rx_data) == CK_PASS);

  always_ff @(posedge clk) begin
    if (!rst_n)         sum <= '0;
    else if (frm_start) sum <= pid_incl ? pid_data : '0;
    else if (ck_fire)   sum <= '0;
    else if (data_fire) sum <= ck_add(sum, rx_data);
  end

  // R10
  sum_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_fire && !frm_start) |=> sum == '0);
endmodule

// File: rtl/lin_cksum_sched.sv
module lin_cksum_sched
  import lin_ck_pkg::*;
#(
  parameter int CNT_FIELD_WP = CNT_FIELD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lin_mode,
  input  logic                    multi_buf,
  input  logic [CNT_FIELD_WP-1:0] data_cnt,
  input  logic                    frame_idle,
  input  logic                    frm_start,
  input  logic                    pid_incl,
  input  logic [BYTE_W-1:0]       pid_data,
  input  logic                    req_set,
  input  logic                    req_clr,
  input  logic                    err_clr,
  input  logic                    rx_valid,
  output logic                    rx_ready,
  input  logic [BYTE_W-1:0]       rx_data,
  output logic                    cmp_done,
  output logic                    ck_err,
  output logic                    req_rb
);
  logic fire, ck_fire, data_fire, idle_arm, match;

  assign fire = rx_valid && rx_ready;

  ck_req_ctrl u_req (
    .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode), .req_set(req_set),
    .req_clr(req_clr), .frame_idle(frame_idle), .ck_fire(ck_fire),
    .req(req_rb), .idle_arm(idle_arm)
  );

  ck_byte_sel #(.CNT_FIELD_W(CNT_FIELD_WP)) u_sel (
    .clk(clk), .rst_n(rst_n), .fire(fire), .frm_start(frm_start),
    .req(req_rb), .idle_arm(idle_arm), .req_clr(req_clr),
    .multi_buf(multi_buf), .data_cnt(data_cnt),
    .ck_fire(ck_fire), .data_fire(data_fire)
  );

  ck_sum_acc u_sum (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .pid_incl(pid_incl),
    .pid_data(pid_data), .data_fire(data_fire), .ck_fire(ck_fire),
    .rx_data(rx_data), .match(match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      cmp_done <= 1'b0;
      ck_err   <= 1'b0;
    end else begin
      rx_ready <= 1'b1;
      cmp_done <= ck_fire;
      if (ck_fire && !match) ck_err <= 1'b1;
      else if (err_clr)      ck_err <= 1'b0;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_err && !err_clr) |=> ck_err);
  // R7
  done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |-> $past(req_rb));
  // R7
  done_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && !$past(req_set)) |-> !req_rb);
  // R9
  clr_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |=> !cmp_done);
endmodule

// File: tb/lin_cksum_sched_test.sv
module lin_cksum_sched_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lin_mode = 1'b1, multi_buf = 1'b0, frame_idle = 1'b0, frm_start = 1'b0;
  logic pid_incl = 1'b0, req_set = 1'b0, req_clr = 1'b0, err_clr = 1'b0;
  logic rx_valid = 1'b0;
  logic [2:0] data_cnt = 3'd0;
  logic [7:0] pid_data = 8'h00, rx_data = 8'h00;
  logic rx_ready, cmp_done, ck_err, req_rb;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  lin_cksum_sched uut (
    .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode), .multi_buf(multi_buf),
    .data_cnt(data_cnt), .frame_idle(frame_idle), .frm_start(frm_start),
    .pid_incl(pid_incl), .pid_data(pid_data), .req_set(req_set),
    .req_clr(req_clr), .err_clr(err_clr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .cmp_done(cmp_done),
    .ck_err(ck_err), .req_rb(req_rb)
  );

  function automatic logic [7:0] add8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; tick(); rx_valid = 1'b0;
  endtask

  task automatic arm();
    req_set = 1'b1; tick(); req_set = 1'b0;
  endtask

  task automatic start(input logic pi, input logic [7:0] pid);
    pid_incl = pi; pid_data = pid; frm_start = 1'b1; tick(); frm_start = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1; tick(); err_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] sum, ck;
    logic exp_err;
    tick(); tick();
    // R1 reset state
    chk("R1 req", {7'd0, req_rb}, 8'd0);
    chk("R1 err", {7'd0, ck_err}, 8'd0);
    chk("R1 done", {7'd0, cmp_done}, 8'd0);
    chk("R1 ready", {7'd0, rx_ready}, 8'd0);
    rst_n = 1'b1; tick();
    chk("R1 ready after reset", {7'd0, rx_ready}, 8'd1);

    // R2 ignored outside LIN mode
    lin_mode = 1'b0; arm();
    chk("R2 off-LIN ignored", {7'd0, req_rb}, 8'd0);
    lin_mode = 1'b1;

    // main sweep: mode x count x pid x arm timing x good/bad
    for (int mb = 0; mb < 2; mb++)
      for (int n = 0; n < 8; n++)
        for (int pi = 0; pi < 2; pi++)
          for (int ai = 0; ai < 2; ai++)
            for (int bad = 0; bad < 2; bad++) begin
              logic [7:0] pid;
              int f;
              f = mb * 64 + n * 8 + pi * 4 + ai * 2 + bad;
              pid = 8'((f * 29 + 3) & 255);
              multi_buf = mb[0]; data_cnt = 3'(n);
              start(pi[0], pid);
              sum = pi ? pid : 8'h00;
              if (mb == 1 && ai == 0) begin
                arm();
                chk("R2 armed", {7'd0, req_rb}, 8'd1);
              end
              for (int i = 0; i <= n; i++) begin
                logic [7:0] d;
                d = 8'((f * 37 + i * 11 + 5) & 255);
                send(d);
                sum = add8(sum, d);
                if (mb == 1 && ai == 0)
                  chk("R4 no early compare", {7'd0, cmp_done}, 8'd0);
              end
              if (!(mb == 1 && ai == 0)) begin
                frame_idle = ai[0];
                arm();
                frame_idle = 1'b0;
              end
              ck = ~sum ^ (bad ? 8'h10 : 8'h00);
              exp_err = (add8(sum, ck) != 8'hFF);
              send(ck);
              if (mb == 0) chk("R3 single-buffer compare", {7'd0, cmp_done}, 8'd1);
              else if (ai == 0) chk("R4 count compare", {7'd0, cmp_done}, 8'd1);
              else chk("R5 idle compare", {7'd0, cmp_done}, 8'd1);
              chk("R6 result", {7'd0, ck_err}, {7'd0, exp_err});
              chk("R7 auto-clear", {7'd0, req_rb}, 8'd0);
              tick();
              chk("R7 one-cycle done", {7'd0, cmp_done}, 8'd0);
              if (ck_err) begin
                clear_err();
                chk("R8 clear", {7'd0, ck_err}, 8'd0);
              end
            end

    // R8 sticky through a passing compare
    multi_buf = 1'b0; start(1'b0, 8'h00);
    send(8'h40); arm(); send(8'h00);
    chk("R8 set", {7'd0, ck_err}, 8'd1);
    send(8'h12); arm(); send(~8'h12);
    chk("R8 sticky pass", {7'd0, ck_err}, 8'd1);
    clear_err();
    chk("R8 cleared", {7'd0, ck_err}, 8'd0);

    // R9 abort on clear during checksum byte
    start(1'b0, 8'h00);
    send(8'h33); arm();
    req_clr = 1'b1; rx_valid = 1'b1; rx_data = 8'h00; tick();
    req_clr = 1'b0; rx_valid = 1'b0;
    chk("R9 no done", {7'd0, cmp_done}, 8'd0);
    chk("R9 req cleared", {7'd0, req_rb}, 8'd0);
    chk("R9 err unchanged", {7'd0, ck_err}, 8'd0);
    arm(); send(~8'h33);
    chk("R9 sum kept", {7'd0, ck_err}, 8'd0);
    chk("R9 done later", {7'd0, cmp_done}, 8'd1);

    // R10 restart after compare, no new frame start
    multi_buf = 1'b1; data_cnt = 3'd7;
    start(1'b1, 8'h5A);
    send(8'h01); frame_idle = 1'b1; arm(); frame_idle = 1'b0;
    send(~add8(8'h5A, 8'h01));
    chk("R10 first", {7'd0, ck_err}, 8'd0);
    send(8'h80); send(8'h90);
    frame_idle = 1'b1; arm(); frame_idle = 1'b0;
    send(~add8(8'h80, 8'h90));
    chk("R10 restarted sum", {7'd0, ck_err}, 8'd0);
    chk("R10 done", {7'd0, cmp_done}, 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule